// File: doc/BRIEF.md
# Droop Set-Point Step Coordinator

Parallel power modules that share a load each carry one copy of this block. It watches a small group of current-threshold comparator outputs. When one of them rises for the first time and its index is still ahead of the number of step pulses already seen on a common wired-OR signal wire, the block drives a single fixed-length pulse onto that wire. Any module whose current runs high therefore tells its neighbours to raise their output-voltage set-points by one step.

On the receive side the block counts pulses that other modules put on the wire. It turns the count into a thermometer-coded bank of enables, and each enable switches in one step of set-point lift. A module that has transmitted even once stops accepting steps. Its own pulses are never counted as received. Steps are never taken back while the block is out of reset, so the improved current balance stays in place when the load falls again.

The comparator inputs and the sensed wire are asynchronous. They pass through synchronizer chains before any decision is made. The wire is driven and sensed on separate pins, and the board forms the wired-OR outside the block.

Top module: `droop_step_coord`

## Requirements
- R1: While reset is high and on the first cycle after it, the drive output is low, every step enable is low and the settled flag is low.
- R2: Each transmitted pulse keeps the drive output high for exactly PULSE_LEN consecutive clock cycles.
- R3: When several threshold inputs rise together and are all eligible, one pulse is sent for each of them, lowest index first, each pulse separate and distinct on the wire.
- R4: Threshold input bit i has index i+1. It may produce a pulse only when i+1 is greater than the total number of pulses seen so far, counting both received pulses and the module's own.
- R5: A threshold input that has already produced a pulse never produces another until reset, however often it falls and rises again.
- R6: Each pulse from another module that arrives while this module has not yet transmitted raises the step count by one, saturating at NUM_THR. Step enable bit j is high exactly when the step count exceeds j.
- R7: Pulses that the module drives itself never raise its own step count.
- R8: Once the module has sent a pulse, pulses from other modules no longer change the step enables, though they still add to the total pulse count.
- R9: The step enables never drop while reset is low, including when the threshold inputs fall.
- R10: The settled output is high exactly when the module has sent a pulse or the total pulse count has reached NUM_THR. Once high it stays high until reset.
- R11: No transmission starts while the synchronized wire is high. A threshold that rises during a foreign pulse is sent only after that pulse has ended, and only if it is still eligible then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_cmp_i | input | NUM_THR | Asynchronous comparator outputs; bit i is threshold index i+1 |
| line_sense_i | input | 1 | Level of the shared wired-OR step wire |
| line_drive_o | output | 1 | Pulls the shared step wire high during a transmitted pulse |
| step_en_o | output | NUM_THR | Thermometer-coded set-point step enables |
| settled_o | output | 1 | This module will take no further set-point steps |

## Verification
The bench goes after the ways a module's own traffic can leak back into its receive path. If the blanking after a transmission is missing, the module counts its own pulse, its step count moves even though it has locked, and its total runs ahead, so a later eligible threshold stays silent. It raises thresholds that are already spent and retriggers fired ones after they fall; a design without the eligibility or fired-flag checks puts extra pulses on the wire, which breaks the rule that each threshold is signalled only once across the system. It raises several thresholds in one cycle, where a design that merges them sends too few pulses, and it holds the wire high during a threshold crossing, where a design that ignores the busy wire starts a pulse that is lost in the foreign one. Random comparator vectors mixed with foreign pulses of varied length check the step enables, the settled flag and the number of pulses sent against a bench model after each event.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_DRIVE = 2'd1,
        TX_GUARD = 2'd2
    } tx_state_e;

    // Bits needed to hold a count from 0 to n inclusive.
    function automatic int ctr_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Quiet cycles after a pulse so the falling edge of our own drive has
    // crossed the sense synchronizer before sensing is re-enabled.
    function automatic int guard_len(input int pulse, input int stages);
        return pulse + stages + 1;
    endfunction

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dsc_tx.sv
module dsc_tx
    import dsc_pkg::*;
#(
    parameter int NUM_THR     = 4,
    parameter int PULSE_LEN   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CW   = ctr_width(NUM_THR),
    localparam int IW   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
    localparam int GLEN = guard_len(PULSE_LEN, SYNC_STAGES),
    localparam int TW   = ctr_width((GLEN > PULSE_LEN) ? GLEN : PULSE_LEN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_THR-1:0] cmp_s,
    input  logic               line_s,
    input  logic [CW-1:0]      seen_cnt,
    output logic               fire_o,
    output logic               drive_o,
    output logic               idle_o,
    output logic               sent_o
);
    tx_state_e          state;
    logic [TW-1:0]      timer;
    logic [NUM_THR-1:0] cmp_prev;
    logic [NUM_THR-1:0] pending;
    logic [NUM_THR-1:0] fired;
    logic [NUM_THR-1:0] rise;
    logic [NUM_THR-1:0] elig;
    logic [IW-1:0]      pick;
    logic               fire;

    always_comb begin
        rise = cmp_s & ~cmp_prev;
        for (int i = 0; i < NUM_THR; i++) begin
            elig[i] = pending[i] && !fired[i] && ((i + 1) > int'(seen_cnt));
        end
        pick = '0;
        for (int i = NUM_THR - 1; i >= 0; i--) begin
            if (elig[i]) pick = IW'(i);
        end
        fire = (state == TX_IDLE) && (|elig) && !line_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            timer    <= '0;
            cmp_prev <= '0;
            pending  <= '0;
            fired    <= '0;
            sent_o   <= 1'b0;
        end else begin
            cmp_prev <= cmp_s;
            pending  <= pending | rise;
            if (fire) begin
                pending[pick] <= 1'b0;
                fired[pick]   <= 1'b1;
                sent_o        <= 1'b1;
            end
            case (state)
                TX_IDLE: begin
                    if (fire) begin
                        state <= TX_DRIVE;
                        timer <= TW'(PULSE_LEN - 1);
                    end
                end
                TX_DRIVE: begin
                    if (timer == '0) begin
                        state <= TX_GUARD;
                        timer <= TW'(GLEN - 1);
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                default: begin
                    if (timer == '0) state <= TX_IDLE;
                    else             timer <= timer - 1'b1;
                end
            endcase
        end
    end

    assign fire_o  = fire;
    assign drive_o = (state == TX_DRIVE);
    assign idle_o  = (state == TX_IDLE);
endmodule

// File: rtl/dsc_rx.sv
module dsc_rx
    import dsc_pkg::*;
#(
    parameter int NUM_THR = 4,
    localparam int CW = ctr_width(NUM_THR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_s,
    input  logic          sense_en,
    input  logic          own_fire,
    input  logic          locked,
    output logic [CW-1:0] seen_cnt,
    output logic [CW-1:0] step_cnt
);
    logic line_prev;
    logic rx_edge;

    assign rx_edge = line_s && !line_prev && sense_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_prev <= 1'b0;
            seen_cnt  <= '0;
            step_cnt  <= '0;
        end else begin
            line_prev <= line_s;
            if ((rx_edge || own_fire) && (int'(seen_cnt) < NUM_THR))
                seen_cnt <= seen_cnt + 1'b1;
            if (rx_edge && !locked && (int'(step_cnt) < NUM_THR))
                step_cnt <= step_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/droop_step_coord.sv
module droop_step_coord
    import dsc_pkg::*;
#(
    parameter int NUM_THR     = 4,
    parameter int PULSE_LEN   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CW = ctr_width(NUM_THR)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_THR-1:0] thr_cmp_i,
    input  logic               line_sense_i,
    output logic               line_drive_o,
    output logic [NUM_THR-1:0] step_en_o,
    output logic               settled_o
);
    logic [NUM_THR-1:0] cmp_s;
    logic               line_s;
    logic [CW-1:0]      seen_cnt;
    logic [CW-1:0]      step_cnt;
    logic               fire;
    logic               tx_idle;
    logic               sent;

    dsc_sync #(.W(NUM_THR), .STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk(clk), .rst(rst), .d(thr_cmp_i), .q(cmp_s)
    );

    dsc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_line_sync (
        .clk(clk), .rst(rst), .d(line_sense_i), .q(line_s)
    );

    dsc_tx #(
        .NUM_THR(NUM_THR), .PULSE_LEN(PULSE_LEN), .SYNC_STAGES(SYNC_STAGES)
    ) u_tx (
        .clk(clk), .rst(rst), .cmp_s(cmp_s), .line_s(line_s),
        .seen_cnt(seen_cnt), .fire_o(fire), .drive_o(line_drive_o),
        .idle_o(tx_idle), .sent_o(sent)
    );

    dsc_rx #(.NUM_THR(NUM_THR)) u_rx (
        .clk(clk), .rst(rst), .line_s(line_s), .sense_en(tx_idle),
        .own_fire(fire), .locked(sent), .seen_cnt(seen_cnt),
        .step_cnt(step_cnt)
    );

    for (genvar j = 0; j < NUM_THR; j++) begin : g_therm
        assign step_en_o[j] = (int'(step_cnt) > j);
    end

    assign settled_o = sent || (int'(seen_cnt) == NUM_THR);
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int NUM_THR   = 4,
    parameter int PULSE_LEN = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               line_drive_o,
    input logic [NUM_THR-1:0] step_en_o,
    input logic               settled_o
);
    localparam int RW = $clog2(PULSE_LEN + 2) + 1;

    logic [RW-1:0] run_cnt;
    logic          has_sent;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            has_sent <= 1'b0;
        end else begin
            has_sent <= has_sent | line_drive_o;
            if (!line_drive_o)            run_cnt <= '0;
            else if (run_cnt != '1)       run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2: a pulse ends after exactly PULSE_LEN high cycles
    a_r2_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $fell(line_drive_o) |-> (run_cnt == RW'(PULSE_LEN)));

    // R6: enables always form a thermometer code
    a_r6_therm_shape: assert property (@(posedge clk) disable iff (rst)
        ((step_en_o & (step_en_o + 1'b1)) == '0));

    // R9: no enable ever drops
    a_r9_no_decrement: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((step_en_o & $past(step_en_o)) == $past(step_en_o)));

    // R8: steps frozen after the module has transmitted
    a_r8_frozen_after_tx: assert property (@(posedge clk) disable iff (rst)
        has_sent |=> $stable(step_en_o));

    // R10: driving implies settled, and settled is sticky
    a_r10_drive_settled: assert property (@(posedge clk) disable iff (rst)
        line_drive_o |-> settled_o);

    a_r10_settled_sticky: assert property (@(posedge clk) disable iff (rst)
        settled_o |=> settled_o);
endmodule

bind droop_step_coord dsc_checker #(.NUM_THR(NUM_THR), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk(clk), .rst(rst), .line_drive_o(line_drive_o),
    .step_en_o(step_en_o), .settled_o(settled_o)
);

// File: tb/droop_step_coord_bench.sv
module droop_step_coord_bench;
    localparam int N  = 4;
    localparam int PL = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] cmp = '0;
    logic         tb_drv = 1'b0;
    logic         line_drive_o;
    logic [N-1:0] step_en_o;
    logic         settled_o;
    logic         line;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model
    int           m_seen, m_rx, m_pulses;
    bit           m_lock;
    logic [N-1:0] m_fired;

    // monitor
    int mon_pulses = 0;
    int mon_run = 0;
    bit mon_prev = 0;

    assign line = line_drive_o | tb_drv;

    droop_step_coord #(.NUM_THR(N), .PULSE_LEN(PL), .SYNC_STAGES(2)) u_droop_step_coord (
        .clk(clk), .rst(rst), .thr_cmp_i(cmp), .line_sense_i(line),
        .line_drive_o(line_drive_o), .step_en_o(step_en_o), .settled_o(settled_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] therm(input int n);
        logic [N-1:0] v = '0;
        for (int j = 0; j < N; j++) if (n > j) v[j] = 1'b1;
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            mon_pulses = 0; mon_run = 0; mon_prev = 0;
        end else begin
            if (line_drive_o) begin
                if (!mon_prev) mon_pulses++;
                mon_run++;
            end else if (mon_prev) begin
                chk("R2 pulse width", mon_run, PL);
                mon_run = 0;
            end
            mon_prev = line_drive_o;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmp = '0; tb_drv = 1'b0;
        repeat (4) @(negedge clk);
        m_seen = 0; m_rx = 0; m_pulses = 0; m_lock = 0; m_fired = '0;
        chk("R1 drive in reset", int'(line_drive_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 steps after reset", int'(step_en_o), 0);
        chk("R1 settled after reset", int'(settled_o), 0);
    endtask

    task automatic model_thr(input logic [N-1:0] nv);
        for (int j = 0; j < N; j++) begin
            if (nv[j] && !cmp[j] && ((j + 1) > m_seen) && !m_fired[j]) begin
                m_fired[j] = 1'b1;
                if (m_seen < N) m_seen++;
                m_lock = 1;
                m_pulses++;
            end
        end
    endtask

    task automatic model_rx();
        if (m_seen < N) m_seen++;
        if (!m_lock && m_rx < N) m_rx++;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R6 steps"}, int'(step_en_o), int'(therm(m_rx)));
        chk({tag, " R10 settled"}, int'(settled_o), int'(m_lock || m_seen == N));
        chk({tag, " R4 pulse count"}, mon_pulses, m_pulses);
    endtask

    task automatic ev_thr(input logic [N-1:0] nv, input string tag);
        model_thr(nv);
        cmp = nv;
        repeat (100) @(negedge clk);
        check_all(tag);
    endtask

    task automatic ev_pulse(input int len, input string tag);
        model_rx();
        tb_drv = 1'b1;
        repeat (len) @(negedge clk);
        tb_drv = 1'b0;
        repeat (30) @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();

        // R4: spent thresholds stay silent, later one fires
        ev_pulse(PL, "R6 first foreign");
        ev_pulse(PL + 2, "R6 second foreign");
        ev_thr(4'b0001, "R4 spent index");
        ev_thr(4'b0101, "R4 eligible index");
        ev_pulse(PL, "R8 after lock");
        chk("R8 steps frozen", int'(step_en_o), 3);

        // R7 and R5: own pulse not counted, no refire
        do_reset();
        ev_thr(4'b0010, "R7 own pulse");
        chk("R7 own steps", int'(step_en_o), 0);
        ev_thr(4'b0000, "R9 fall");
        ev_thr(4'b0010, "R5 refire");
        chk("R5 single pulse", mon_pulses, 1);

        // R3: several together
        do_reset();
        ev_thr(4'b0111, "R3 burst");
        chk("R3 three pulses", mon_pulses, 3);

        // R9: steps kept after comparators fall
        do_reset();
        ev_pulse(PL, "R9 setup");
        ev_pulse(PL, "R9 setup2");
        ev_thr(4'b0000, "R9 drop");
        chk("R9 kept", int'(step_en_o), 3);

        // R11: no start while wire busy
        do_reset();
        model_rx();
        tb_drv = 1'b1;
        repeat (10) @(negedge clk);
        model_thr(4'b0010);
        cmp = 4'b0010;
        repeat (25) @(negedge clk);
        chk("R11 silent while busy", mon_pulses, 0);
        tb_drv = 1'b0;
        repeat (60) @(negedge clk);
        check_all("R11 after release");
        chk("R11 sent later", mon_pulses, 1);

        // random runs
        for (int run = 0; run < 8; run++) begin
            do_reset();
            for (int e = 0; e < 14; e++) begin
                if ($urandom_range(0, 2) == 0)
                    ev_pulse(PL + int'($urandom_range(0, 5)), "rand R6 R8");
                else
                    ev_thr(N'($urandom), "rand R4 R5");
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule